// File: doc/BRIEF.md
# Serial Flash Configuration Loader

This block fetches a configuration image from an external serial flash at power-up. After reset, and once its active-low chain-enable input is low, it pulls the flash select low. It then shifts a read opcode and a 24-bit start address out on a serial data line. Next it collects a fixed number of image bits from the flash's serial output and hands them on as bytes over a one-cycle valid strobe with a data bus.

The serial clock comes from the system clock through a divider. The divider is derived from the system clock frequency so that the serial clock stays inside a 20 to 40 MHz window. While idle, every line toward the flash rests high. The loader updates its select and data lines only when the serial clock falls, and the flash captures them on the rising edge. Returned data is also captured when the serial clock falls. Once the last bit is in, the clock stops, the flash is released, the done output goes high and the active-low chain output goes low, so that a next loader on the shared flash can start.

Top module: `cfg_flash_loader`

## Requirements
- R1: While in reset, or while no transaction is in progress, cs_no, sck_o and mosi_o are high and byte_valid_o is low; done_o is low and chain_en_no is high until the load completes.
- R2: A load starts only on a clock edge where chain_en_ni is low. While chain_en_ni is high, the loader stays idle with cs_no high.
- R3: Each sck_o half period lasts HALF = ceil(SYS_MHZ/80) system clocks. With SYS_MHZ = 125 this is 2 cycles, giving 31.25 MHz. The first sck_o edge of a load is a falling edge, made in the same cycle that cs_no goes low.
- R4: cs_no stays low without a break from the first falling edge of sck_o until the final slot of the load.
- R5: mosi_o carries the 32-bit word {opcode 8'h03, START_ADDR[23:0]}, most significant bit first. Bit k (counting from 0 at the MSB) is presented at falling edge k+1. mosi_o changes only on falling sck_o edges and is high from falling edge 33 onward.
- R6: Image bit j is captured from miso_i at the slot of falling edge 34+j. That is the falling edge after the one on which the flash put the bit out.
- R7: Captured bits are packed MSB first into bytes. byte_valid_o is high for exactly one system clock, in the cycle where the eighth bit of a byte is captured, and byte_data_o holds that byte during that cycle.
- R8: At the slot of falling edge 33+CFG_BITS, the last bit is captured. In that same cycle sck_o stays high, cs_no goes high, done_o goes high and chain_en_no goes low.
- R9: After completion, done_o stays high and chain_en_no stays low until reset, whatever chain_en_ni does. sck_o, cs_no and mosi_o stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chain_en_ni | input | 1 | Active-low start permission; tied low on the first loader of a chain |
| miso_i | input | 1 | Serial data returned by the flash |
| sck_o | output | 1 | Serial clock to the flash, idle high |
| cs_no | output | 1 | Active-low flash select |
| mosi_o | output | 1 | Serial command and address to the flash, idle high |
| byte_valid_o | output | 1 | One-cycle strobe for each assembled byte |
| byte_data_o | output | 8 | Assembled image byte |
| done_o | output | 1 | High once the whole image has been read |
| chain_en_no | output | 1 | Active-low enable for the next loader, low after completion |

## Verification
A slot counter that is off by one moves the first capture or the final slot by one half period. In the first case every byte reaching byte_data_o carries the wrong bits from the first strobe onward. In the second case the rise of cs_no and done_o lands in the wrong cycle. A divider phase error changes the spacing of sck_o edges within two edges of the start. A fault in the command shifter corrupts the opcode or address seen by the flash within the first 32 serial clocks. Because the reference model predicts every output in every cycle, each of these faults shows up in the first cycle where it has an effect.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ld_state_e;

  localparam int unsigned CMD_BITS = 32;
endpackage

// File: rtl/cfg_ld_clkgen.sv
module cfg_ld_clkgen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic start_i,
  input  logic stop_i,
  output logic sck_o,
  output logic fall_slot_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          sck_q;
  logic          tick;

  assign tick        = run_i && (cnt_q == CW'(HALF_DIV - 1));
  assign fall_slot_o = tick && sck_q;
  assign sck_o       = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else begin
      if (!run_i || tick) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
      if (start_i)   sck_q <= 1'b0;
      else if (tick) sck_q <= sck_q ? stop_i : 1'b1; // final fall slot keeps clock high
    end
  end
endmodule

// File: rtl/cfg_ld_cmd_tx.sv
module cfg_ld_cmd_tx #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         shift_i,
  output logic         bit_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '1;
    else if (load_i)  sr_q <= word_i;
    else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b1}; // backfill ones: line rests high
  end

  assign bit_o = sr_q[W-1];
endmodule

// File: rtl/cfg_ld_packer.sv
module cfg_ld_packer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sample_i,
  input  logic         bit_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  localparam int unsigned CW = $clog2(W);

  logic [W-2:0] sh_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      if (sample_i) begin
        sh_q  <= {sh_q[W-3:0], bit_i};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(W - 1)) begin
          data_o  <= {sh_q, bit_i};
          valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_flash_loader.sv
module cfg_flash_loader
  import cfg_ld_pkg::*;
#(
  parameter int unsigned SYS_MHZ    = 125,
  parameter int unsigned CFG_BITS   = 4096,
  parameter logic [7:0]  RD_OPCODE  = 8'h03,
  parameter logic [23:0] START_ADDR = 24'h000000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       chain_en_ni,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       cs_no,
  output logic       mosi_o,
  output logic       byte_valid_o,
  output logic [7:0] byte_data_o,
  output logic       done_o,
  output logic       chain_en_no
);
  // fastest divider keeping the serial clock at or below 40 MHz
  localparam int unsigned HALF_DIV = (SYS_MHZ + 79) / 80;
  localparam int unsigned SLOTS    = CMD_BITS + CFG_BITS;
  localparam int unsigned RW       = $clog2(SLOTS + 1);

  ld_state_e      state_q;
  logic [RW-1:0]  rem_q;      // falling-edge slots still to come
  logic           start, run, slot, last, sample;

  assign start  = (state_q == ST_IDLE) && !chain_en_ni;
  assign run    = (state_q == ST_RUN);
  assign last   = slot && (rem_q == RW'(1));
  assign sample = slot && (rem_q <= RW'(CFG_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rem_q       <= '0;
      cs_no       <= 1'b1;
      done_o      <= 1'b0;
      chain_en_no <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_RUN;
          rem_q   <= RW'(SLOTS);
          cs_no   <= 1'b0;
        end
        ST_RUN: if (slot) begin
          rem_q <= rem_q - 1'b1;
          if (last) begin
            state_q     <= ST_DONE;
            cs_no       <= 1'b1;
            done_o      <= 1'b1;
            chain_en_no <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  cfg_ld_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .start_i     (start),
    .stop_i      (last),
    .sck_o       (sck_o),
    .fall_slot_o (slot)
  );

  cfg_ld_cmd_tx #(.W(CMD_BITS)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start),
    .word_i  ({RD_OPCODE, START_ADDR}),
    .shift_i (slot && run),
    .bit_o   (mosi_o)
  );

  cfg_ld_packer #(.W(8)) u_pack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample),
    .bit_i    (miso_i),
    .valid_o  (byte_valid_o),
    .data_o   (byte_data_o)
  );
endmodule

// File: rtl/cfg_ld_checker.sv
module cfg_ld_checker #(
  parameter int unsigned HALF_DIV = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic chain_en_ni,
  input logic sck_o,
  input logic cs_no,
  input logic mosi_o,
  input logic byte_valid_o,
  input logic done_o,
  input logic chain_en_no
);
  logic [15:0] gap_q;
  logic        sck_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q      <= '0;
      sck_prev_q <= 1'b1;
    end else begin
      sck_prev_q <= sck_o;
      if (sck_o != sck_prev_q) gap_q <= '0;
      else if (gap_q != 16'hFFFF) gap_q <= gap_q + 1'b1;
    end
  end

  AST_IDLE_LINES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> (sck_o && mosi_o)); // R1
  AST_NOT_DONE_CHAIN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> chain_en_no); // R1
  AST_NO_START_WITHOUT_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_no && !done_o && chain_en_ni) |=> cs_no); // R2
  AST_SCK_HALF_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $past(!cs_no) && (sck_o != $past(sck_o))) |-> (gap_q == 16'(HALF_DIV - 1))); // R3
  AST_MOSI_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $past(!cs_no) && (mosi_o != $past(mosi_o))) |-> $fell(sck_o)); // R5
  AST_VALID_AT_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> (cs_no ? $rose(cs_no) : $fell(sck_o))); // R7
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o); // R7
  AST_FINISH_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (done_o && !chain_en_no && sck_o)); // R8
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && !chain_en_no && cs_no)); // R9
endmodule

bind cfg_flash_loader cfg_ld_checker #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .chain_en_ni  (chain_en_ni),
  .sck_o        (sck_o),
  .cs_no        (cs_no),
  .mosi_o       (mosi_o),
  .byte_valid_o (byte_valid_o),
  .done_o       (done_o),
  .chain_en_no  (chain_en_no)
);

// File: tb/sim_cfg_flash_loader.sv
module sim_cfg_flash_loader;
  localparam int          NB   = 64;
  localparam int          HALF = 2; // ceil(125/80)
  localparam logic [23:0] ADDR = 24'hA51C3E;
  localparam logic [31:0] CMD  = {8'h03, ADDR};
  localparam int          MFIN = 2 * (32 + NB);

  logic       clk = 1'b0, rst_n = 1'b0, en_n = 1'b1, miso = 1'b1;
  logic       sck, cs_n, mosi, bvalid, done, chain_n;
  logic [7:0] bdata;

  int tests = 0, fails = 0, t = 0, seed = 1, nbytes = 0;
  bit trk = 0, ended = 0;
  int rx_n = 0, dbit = 0;
  logic [31:0] rx_w = '0, cmd_seen = '0;
  logic p_sck = 1'b1;

  always #4 clk = ~clk;

  cfg_flash_loader #(.SYS_MHZ(125), .CFG_BITS(NB), .RD_OPCODE(8'h03), .START_ADDR(ADDR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .chain_en_ni(en_n), .miso_i(miso),
    .sck_o(sck), .cs_no(cs_n), .mosi_o(mosi), .byte_valid_o(bvalid),
    .byte_data_o(bdata), .done_o(done), .chain_en_no(chain_n)
  );

  function automatic logic [7:0] pat(int s, int b);
    return 8'((b * 29 + s * 71 + 5) ^ (b << 3));
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0d", req, act, exp, t);
    end
  endtask

  task automatic chk_idle(string req);
    chk({sck, cs_n, mosi} == 3'b111, req, {sck, cs_n, mosi}, 3'b111);
    chk({bvalid, done, chain_n} == 3'b001, req, {bvalid, done, chain_n}, 3'b001);
  endtask

  // behavioural flash: captures on rising sck, drives data after falling sck
  task automatic flash_step();
    logic [7:0] v;
    if (cs_n) begin
      rx_n = 0; dbit = 0; rx_w = '0; miso = 1'b1;
    end else begin
      if (!p_sck && sck && rx_n < 32) begin
        rx_w = {rx_w[30:0], mosi};
        rx_n++;
        if (rx_n == 32) cmd_seen = rx_w;
      end else if (p_sck && !sck && rx_n == 32 && dbit < NB) begin
        v = pat(seed, dbit / 8);
        miso = v[7 - dbit % 8];
        dbit++;
      end
    end
    p_sck = sck;
  endtask

  task automatic check_cycle();
    int m = t / HALF;
    int f = m / 2 + 1;
    bit ev;
    int b;
    if (m < MFIN) begin
      chk(sck == 1'(m % 2), "R3", sck, 1'(m % 2));
      chk(cs_n == 1'b0, "R4", cs_n, 0);
      chk(mosi == ((f <= 32) ? CMD[32 - f] : 1'b1), "R5", mosi, (f <= 32) ? CMD[32 - f] : 1'b1);
      chk({done, chain_n} == 2'b01, "R8", {done, chain_n}, 2'b01);
    end else begin
      chk({sck, cs_n, mosi} == 3'b111, "R8", {sck, cs_n, mosi}, 3'b111);
      chk({done, chain_n} == 2'b10, "R9", {done, chain_n}, 2'b10);
    end
    ev = (t % HALF == 0) && (m % 2 == 0) && (m >= 80) && (m <= MFIN) && (((m / 2) - 40) % 8 == 0);
    chk(bvalid == ev, "R7", bvalid, ev);
    if (ev) begin
      b = ((m / 2) - 40) / 8;
      nbytes++;
      chk(bdata == pat(seed, b), "R6", bdata, pat(seed, b));
    end
  endtask

  task automatic step();
    @(negedge clk);
    flash_step();
    if (trk) begin
      check_cycle();
      t++;
    end
  endtask

  task automatic full_run(int s);
    seed = s; nbytes = 0; cmd_seen = '0;
    en_n = 1'b0; trk = 1; t = 0;
    repeat (HALF * MFIN + 10) step();
    en_n = 1'b1;               // R9: later enable changes ignored
    repeat (12) step();
    trk = 0;
    chk(cmd_seen == CMD, "R5", cmd_seen, CMD);
    chk(nbytes == NB / 8, "R7", nbytes, NB / 8);
  endtask

  initial begin
    repeat (3) begin step(); chk_idle("R1"); end
    rst_n = 1'b1;
    repeat (20) begin step(); chk_idle("R2"); end
    full_run(1);
    rst_n = 1'b0;
    step(); chk_idle("R1");
    rst_n = 1'b1;
    en_n = 1'b0; trk = 1; t = 0; seed = 2;
    repeat (150) step();
    trk = 0; rst_n = 1'b0; en_n = 1'b1;  // abort mid-load
    step(); chk_idle("R1");
    rst_n = 1'b1;
    repeat (6) begin step(); chk_idle("R2"); end
    full_run(2);
    ended = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      fails++; tests++;
      $display("FAIL R8 watchdog act=%0h exp=%0h", done, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule